// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master with External Bypass

This block is the PHY management port of a switch. Software issues a single 32-bit command word, written to one control/status register over a simple internal register bus, to start a Clause 22 read or write of a PHY register. While the frame is on the wire the busy flag stays set. It clears by itself when the last bit has been clocked out, and after a read the captured PHY data sits in the low half of the same register. The serializer derives MDC from the system clock through a divider and sends the preamble, which can be left out. On reads it releases MDIO for the turnaround and the data bits.

The block also owns the path to the internal PHYs. While the enable bit is clear, an external management master's MDC/MDIO reaches the PHYs unchanged. While the enable bit is set, that external path is cut off and the internal engine drives the PHY side. The two access methods are therefore exclusive. A later register write that clears the enable bit hands the PHYs back to the external master.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000, phy_mdc is 0 with ext_mdc at 0, and the external path reaches the PHYs.
- R2: The register sits at byte offset 0x3C; any other address reads 0. Its layout is: bit 31 busy, bit 30 enable, bit 27 read (1) or write (0), bit 26 no-preamble, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. All other bits read 0.
- R3: A write to 0x3C with bits 31 and 30 both set and a PHY address below NUM_PHY starts a frame while the block is idle. Busy then reads 1 for exactly 2*DIV_HALF clocks per frame bit: 64 bits, or 32 bits with no-preamble, and then clears by itself.
- R4: The frame seen on MDIO at each rising MDC edge is, MSB first: 32 ones (dropped when no-preamble is set), 01, opcode 10 for read or 01 for write, PHY address, register address, turnaround 10, then 16 data bits.
- R5: On a read the master drives MDIO (phy_mdio_oe=1) only for the bits before the turnaround, and releases it for the 2 turnaround bits and the 16 data bits. On a write it drives every bit.
- R6: On a read, the 16 data bits sampled on the rising MDC edges are returned in bits 15:0 once busy has cleared. On a write, bits 15:0 return the write data.
- R7: MDC is low for the first DIV_HALF clocks and high for the last DIV_HALF clocks of each bit, giving one rising edge per frame bit. It stays low while enable is set and no frame is running.
- R8: A register write while busy is 1 is ignored. The frame in flight and all latched fields are unchanged.
- R9: A start request whose PHY address is NUM_PHY or higher does not set busy and sends nothing. Only the enable bit is taken from the word.
- R10: While enable is 0, phy_mdc, phy_mdio_o and phy_mdio_oe follow ext_mdc, ext_mdio_o and ext_mdio_oe, and ext_mdio_i follows phy_mdio_i.
- R11: While enable is 1, the external inputs do not reach the PHYs, ext_mdio_i reads 1, and busy can only be 1 while enable is 1.
- R12: A write without bit 31 set only updates enable. Writing enable as 0 restores the external path of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on address) |
| ext_mdc | input | 1 | MDC from the external management master |
| ext_mdio_o | input | 1 | MDIO data from the external master |
| ext_mdio_oe | input | 1 | MDIO drive enable from the external master |
| ext_mdio_i | output | 1 | MDIO data returned to the external master |
| phy_mdc | output | 1 | MDC toward the internal PHYs |
| phy_mdio_o | output | 1 | MDIO data toward the PHYs |
| phy_mdio_oe | output | 1 | MDIO drive enable toward the PHYs |
| phy_mdio_i | input | 1 | MDIO data from the PHYs |

## Verification
The bench builds the block with DIV_HALF=2 and NUM_PHY=5. With DIV_HALF=2 a full frame lasts 256 clocks and a short frame 128, so exact busy lengths can be compared for several reads and writes, both with and without preamble, well within the run limit. NUM_PHY=5 puts the address boundary at 4 (accepted) and 5 (refused), and both are exercised. A behavioural PHY on the bench side answers reads after the turnaround, so read capture and bus release are observed on real wire traffic.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int WORD_W     = 32;
    localparam int BUSY_BIT   = 31;
    localparam int EN_BIT     = 30;
    localparam int RD_BIT     = 27;
    localparam int NOPRE_BIT  = 26;
    localparam int PHY_LSB    = 21;
    localparam int REG_LSB    = 16;
    localparam int ADR_W      = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_MAX  = 64;
    localparam int CNT_W      = $clog2(FRAME_MAX);
    localparam int RELEASE_AT = DATA_W + 2;

    typedef struct packed {
        logic              busy;
        logic              en;
        logic              rd;
        logic              nopre;
        logic [ADR_W-1:0]  phy;
        logic [ADR_W-1:0]  regad;
        logic [DATA_W-1:0] data;
    } csr_t;

    function automatic logic [WORD_W-1:0] pack_csr(csr_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BUSY_BIT]                  = c.busy;
        w[EN_BIT]                    = c.en;
        w[RD_BIT]                    = c.rd;
        w[NOPRE_BIT]                 = c.nopre;
        w[PHY_LSB +: ADR_W]          = c.phy;
        w[REG_LSB +: ADR_W]          = c.regad;
        w[DATA_W-1:0]                = c.data;
        return w;
    endfunction

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic              nopre_i,
    input  logic [ADR_W-1:0]  phy_i,
    input  logic [ADR_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tick_i,
    input  logic              mdio_i,
    output logic              run_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic                 active;
        logic                 half;
        logic                 rd;
        logic [CNT_W-1:0]     cnt;
        logic [FRAME_MAX-1:0] shreg;
        logic [DATA_W-1:0]    cap;
    } eng_t;

    eng_t q, d;
    logic [PRE_BITS-1:0]  body;
    logic [FRAME_MAX-1:0] frame;

    always_comb begin
        body  = {2'b01, (rd_i ? 2'b10 : 2'b01), phy_i, reg_i, 2'b10,
                 (rd_i ? {DATA_W{1'b0}} : wdata_i)};
        frame = nopre_i ? {body, {PRE_BITS{1'b0}}} : {{PRE_BITS{1'b1}}, body};
    end

    always_comb begin
        d      = q;
        done_o = 1'b0;
        if (start_i && !q.active) begin
            d.active = 1'b1;
            d.half   = 1'b0;
            d.rd     = rd_i;
            d.cnt    = nopre_i ? CNT_W'(FRAME_MAX - PRE_BITS - 1) : CNT_W'(FRAME_MAX - 1);
            d.shreg  = frame;
        end else if (q.active && tick_i) begin
            if (!q.half) begin
                d.half = 1'b1;
                if (q.rd && (q.cnt < CNT_W'(DATA_W)))
                    d.cap = {q.cap[DATA_W-2:0], mdio_i};
            end else begin
                d.half = 1'b0;
                if (q.cnt == '0) begin
                    d.active = 1'b0;
                    done_o   = 1'b1;
                end else begin
                    d.cnt   = q.cnt - 1'b1;
                    d.shreg = {q.shreg[FRAME_MAX-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run_o     = q.active;
    assign mdc_o     = q.active & q.half;
    assign mdio_o    = q.active ? q.shreg[FRAME_MAX-1] : 1'b1;
    assign mdio_oe_o = q.active && (!q.rd || (q.cnt >= CNT_W'(RELEASE_AT)));
    assign rdata_o   = q.cap;
endmodule

// File: rtl/mdio_path_mux.sv
module mdio_path_mux (
    input  logic sel_int_i,
    input  logic int_mdc_i,
    input  logic int_mdio_o_i,
    input  logic int_mdio_oe_i,
    input  logic ext_mdc_i,
    input  logic ext_mdio_o_i,
    input  logic ext_mdio_oe_i,
    input  logic phy_mdio_i,
    output logic ext_mdio_i_o,
    output logic phy_mdc_o,
    output logic phy_mdio_o,
    output logic phy_mdio_oe_o
);
    always_comb begin
        if (sel_int_i) begin
            phy_mdc_o     = int_mdc_i;
            phy_mdio_o    = int_mdio_o_i;
            phy_mdio_oe_o = int_mdio_oe_i;
            ext_mdio_i_o  = 1'b1;
        end else begin
            phy_mdc_o     = ext_mdc_i;
            phy_mdio_o    = ext_mdio_o_i;
            phy_mdio_oe_o = ext_mdio_oe_i;
            ext_mdio_i_o  = phy_mdio_i;
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  CSR_OFFSET = 8'h3C,
    parameter int          DIV_HALF   = 4,
    parameter int          NUM_PHY    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ext_mdc,
    input  logic              ext_mdio_o,
    input  logic              ext_mdio_oe,
    output logic              ext_mdio_i,
    output logic              phy_mdc,
    output logic              phy_mdio_o,
    output logic              phy_mdio_oe,
    input  logic              phy_mdio_i
);
    csr_t csr_d, csr_q;

    logic              hit_w, start_req, start_w;
    logic              tick_w, run_w, done_w;
    logic              eng_mdc, eng_mdio, eng_oe;
    logic [DATA_W-1:0] eng_rdata;
    logic              busy_w, en_w, rd_w;
    logic [ADR_W-1:0]  phy_w;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[29:28], run_w};
    assign hit_w       = bus_wr && (bus_addr == ADDR_W'(CSR_OFFSET));
    assign start_req   = bus_wdata[BUSY_BIT] && bus_wdata[EN_BIT] &&
                         (32'(bus_wdata[PHY_LSB +: ADR_W]) < NUM_PHY);
    assign start_w     = hit_w && !csr_q.busy && start_req;

    always_comb begin
        csr_d = csr_q;
        if (done_w) begin
            csr_d.busy = 1'b0;
            if (csr_q.rd) csr_d.data = eng_rdata;
        end
        if (hit_w && !csr_q.busy) begin
            if (start_req) begin
                csr_d.busy  = 1'b1;
                csr_d.en    = 1'b1;
                csr_d.rd    = bus_wdata[RD_BIT];
                csr_d.nopre = bus_wdata[NOPRE_BIT];
                csr_d.phy   = bus_wdata[PHY_LSB +: ADR_W];
                csr_d.regad = bus_wdata[REG_LSB +: ADR_W];
                csr_d.data  = bus_wdata[DATA_W-1:0];
            end else begin
                csr_d.en    = bus_wdata[EN_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    assign bus_rdata = (bus_addr == ADDR_W'(CSR_OFFSET)) ? pack_csr(csr_q) : '0;

    assign busy_w = csr_q.busy;
    assign en_w   = csr_q.en;
    assign rd_w   = csr_q.rd;
    assign phy_w  = csr_q.phy;

    mdio_tick_gen #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_w),
        .tick_o (tick_w)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_w),
        .rd_i      (bus_wdata[RD_BIT]),
        .nopre_i   (bus_wdata[NOPRE_BIT]),
        .phy_i     (bus_wdata[PHY_LSB +: ADR_W]),
        .reg_i     (bus_wdata[REG_LSB +: ADR_W]),
        .wdata_i   (bus_wdata[DATA_W-1:0]),
        .tick_i    (tick_w),
        .mdio_i    (phy_mdio_i),
        .run_o     (run_w),
        .mdc_o     (eng_mdc),
        .mdio_o    (eng_mdio),
        .mdio_oe_o (eng_oe),
        .done_o    (done_w),
        .rdata_o   (eng_rdata)
    );

    mdio_path_mux u_mux (
        .sel_int_i     (en_w),
        .int_mdc_i     (eng_mdc),
        .int_mdio_o_i  (eng_mdio),
        .int_mdio_oe_i (eng_oe),
        .ext_mdc_i     (ext_mdc),
        .ext_mdio_o_i  (ext_mdio_o),
        .ext_mdio_oe_i (ext_mdio_oe),
        .phy_mdio_i    (phy_mdio_i),
        .ext_mdio_i_o  (ext_mdio_i),
        .phy_mdc_o     (phy_mdc),
        .phy_mdio_o    (phy_mdio_o),
        .phy_mdio_oe_o (phy_mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
    parameter int NUM_PHY = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hit,
    input logic [31:0] wdata,
    input logic        busy,
    input logic        en,
    input logic        cmd_rd,
    input logic [4:0]  phy,
    input logic        phy_mdc,
    input logic        phy_mdio_oe
);
    // R3: an accepted start raises busy on the next cycle
    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !busy && wdata[31] && wdata[30] && (32'(wdata[25:21]) < NUM_PHY)) |=> busy);

    // R5: a write frame keeps MDIO driven throughout
    assert_write_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_rd) |-> phy_mdio_oe);

    // R7: MDC rests low while the engine owns the PHYs and is idle
    assert_mdc_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !busy) |-> !phy_mdc);

    // R8: a write during a frame leaves the latched command alone
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit) |=> ($stable(phy) && $stable(cmd_rd)));

    // R9: an out-of-range PHY address never starts a frame
    assert_no_start_oor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && hit && wdata[31] && (32'(wdata[25:21]) >= NUM_PHY)) |=> !busy);

    // R11: a frame only runs while the external path is cut off
    assert_busy_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> en);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.NUM_PHY(NUM_PHY)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit_w),
    .wdata       (bus_wdata),
    .busy        (busy_w),
    .en          (en_w),
    .cmd_rd      (rd_w),
    .phy         (phy_w),
    .phy_mdc     (phy_mdc),
    .phy_mdio_oe (phy_mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
    localparam int DIV_HALF = 2;
    localparam int NUM_PHY  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h3C;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_mdc = 1'b0, ext_mdio_o = 1'b1, ext_mdio_oe = 1'b0;
    logic        ext_mdio_i;
    logic        phy_mdc, phy_mdio_o, phy_mdio_oe;
    logic        phy_in = 1'b1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // frame bookkeeping of the bench-side PHY
    logic [63:0] exp_frame = '0;
    int          exp_bits  = 64;
    logic [63:0] rec = '0;
    int          rises = 0;
    int          oe_bits = 0;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF), .NUM_PHY(NUM_PHY)) u_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_mdc(ext_mdc), .ext_mdio_o(ext_mdio_o), .ext_mdio_oe(ext_mdio_oe),
        .ext_mdio_i(ext_mdio_i), .phy_mdc(phy_mdc), .phy_mdio_o(phy_mdio_o),
        .phy_mdio_oe(phy_mdio_oe), .phy_mdio_i(phy_in)
    );

    always @(posedge phy_mdc) begin
        rec     <= {rec[62:0], (phy_mdio_oe ? phy_mdio_o : phy_in)};
        oe_bits <= oe_bits + (phy_mdio_oe ? 1 : 0);
        rises   <= rises + 1;
    end

    always @(negedge phy_mdc) begin
        if (rises < exp_bits) phy_in <= exp_frame[exp_bits - 1 - rises];
        else                  phy_in <= 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] wire_frame(logic rd, logic sup, logic [4:0] p,
                                               logic [4:0] r, logic [15:0] d);
        logic [31:0] h;
        h = {2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
        return sup ? {32'h0, h} : {32'hFFFF_FFFF, h};
    endfunction

    task automatic arm(input logic rd, input logic sup, input logic [4:0] p,
                       input logic [4:0] r, input logic [15:0] d);
        exp_frame = wire_frame(rd, sup, p, r, d);
        exp_bits  = sup ? 32 : 64;
        rec       = '0;
        rises     = 0;
        oe_bits   = 0;
        phy_in    = exp_frame[exp_bits - 1];
    endtask

    task automatic bus_write(input logic [31:0] w);
        bus_addr  = 8'h3C;
        bus_wdata = w;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (bus_rdata[31] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // {rd, nopre, phy, reg, data-or-reply}
    localparam logic [27:0] VEC [0:4] = '{
        {1'b0, 1'b0, 5'd0, 5'd0,  16'hA5C3},
        {1'b1, 1'b0, 5'd4, 5'd31, 16'h1234},
        {1'b0, 1'b1, 5'd2, 5'd9,  16'hFFFF},
        {1'b1, 1'b1, 5'd1, 5'd5,  16'h8001},
        {1'b1, 1'b0, 5'd3, 5'd16, 16'h0000}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] word;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 reset word", 64'(bus_rdata), 64'h0);
        chk("R1 mdc idle", 64'(phy_mdc), 64'h0);

        // R2: other addresses read zero
        bus_addr = 8'h38;
        #1 chk("R2 other offset", 64'(bus_rdata), 64'h0);
        bus_addr = 8'h3C;

        // R10: passthrough with enable clear
        ext_mdc = 1'b1; ext_mdio_o = 1'b0; ext_mdio_oe = 1'b1; phy_in = 1'b0;
        #1;
        chk("R10 mdc follows", 64'(phy_mdc), 64'h1);
        chk("R10 mdio follows", 64'({phy_mdio_o, phy_mdio_oe}), 64'h1);
        chk("R10 return path", 64'(ext_mdio_i), 64'h0);

        // R11: enable cuts off the external path
        bus_write(32'h4000_0000);
        chk("R11 mdc blocked", 64'(phy_mdc), 64'h0);
        chk("R11 return idle", 64'(ext_mdio_i), 64'h1);
        chk("R12 enable only", 64'(bus_rdata), 64'h4000_0000);
        ext_mdc = 1'b0; ext_mdio_o = 1'b1; ext_mdio_oe = 1'b0; phy_in = 1'b1;

        // R3 R4 R5 R6 R7: vector table
        for (int i = 0; i < 5; i++) begin
            logic rd, sup;
            logic [4:0] p, r;
            logic [15:0] d;
            {rd, sup, p, r, d} = VEC[i];
            arm(rd, sup, p, r, d);
            bus_write({1'b1, 1'b1, 2'b00, rd, sup, p, r, (rd ? 16'h0 : d)});
            wait_idle(n);
            chk("R3 busy length", 64'(n), 64'((sup ? 32 : 64) * 2 * DIV_HALF));
            chk("R4 wire frame", rec, exp_frame);
            chk("R5 drive bits", 64'(oe_bits), 64'(rd ? exp_bits - 18 : exp_bits));
            chk("R7 mdc rises", 64'(rises), 64'(exp_bits));
            chk("R6 readback", 64'(bus_rdata),
                64'({1'b0, 1'b1, 2'b00, rd, sup, p, r, d}));
            @(negedge clk);
            chk("R7 mdc idle low", 64'(phy_mdc), 64'h0);
        end

        // R8: write during a frame is ignored
        arm(1'b0, 1'b0, 5'd2, 5'd3, 16'h0F0F);
        bus_write(32'hC000_0000 | (32'd2 << 21) | (32'd3 << 16) | 32'h0F0F);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            if (!bus_rdata[31]) break;
            n++;
            if (i == 8) begin
                bus_wdata = 32'hCC00_0000 | (32'd1 << 21) | (32'd1 << 16);
                bus_wr    = 1'b1;
            end else begin
                bus_wr    = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        chk("R8 frame length kept", 64'(n), 64'(64 * 2 * DIV_HALF));
        chk("R8 frame kept", rec, exp_frame);
        word = 32'h4000_0000 | (32'd2 << 21) | (32'd3 << 16) | 32'h0F0F;
        chk("R8 fields kept", 64'(bus_rdata), 64'(word));

        // R9: PHY address at the limit is refused
        arm(1'b0, 1'b0, 5'd5, 5'd2, 16'h1111);
        bus_write(32'hC000_0000 | (32'd5 << 21) | (32'd2 << 16) | 32'h1111);
        chk("R9 busy stays low", 64'(bus_rdata[31]), 64'h0);
        repeat (20) @(negedge clk);
        chk("R9 nothing sent", 64'(rises), 64'h0);
        chk("R9 fields kept", 64'(bus_rdata), 64'(word));

        // R12: clearing enable restores passthrough
        bus_write(32'h0000_0000);
        chk("R12 enable cleared", 64'(bus_rdata), 64'(word & 32'hBFFF_FFFF));
        ext_mdc = 1'b1; phy_in = 1'b0;
        #1;
        chk("R12 mdc restored", 64'(phy_mdc), 64'h1);
        chk("R12 return restored", 64'(ext_mdio_i), 64'h0);
        ext_mdc = 1'b0; phy_in = 1'b1;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule